// File: doc/BRIEF.md
# Hex-Digit Restoring Float Divider

This block divides one 32-bit base-16 floating-point word by another. In the word format, bit 31 is the sign (1 = minus). Bits 30:24 hold a power-of-sixteen exponent in excess-64 code. Bits 23:0 hold a six-hex-digit fraction read as .hhhhhh. A one-cycle start strobe captures both operands. The block normalizes each operand by shifting out leading zero hex digits, and an operand whose fraction is zero counts as a clean zero.

If the dividend fraction is below the divisor fraction, the dividend is pre-scaled by one hex digit so that every quotient digit stays in the range 0 to 15. The six quotient digits are then developed by restoring division, with one subtraction per clock. After the sixth digit the final remainder decides whether to round up. The result is then checked against the exponent range. The packed quotient, a three-bit condition code and a divide-check flag are presented together with a one-cycle done pulse.

Top module: `hex_float_div`

## Requirements
- R1: After reset, quotientOut, condCode, divCheck and doneOut are all zero.
- R2: For nonzero normalized operands, the quotient fraction is the first six hex digits of the fraction ratio. The biased exponent is dividend exponent minus divisor exponent plus 65 when the dividend fraction is at least the divisor fraction.
- R3: The quotient sign (bit 31) is the XOR of the two operand signs.
- R4: When the dividend fraction is smaller than the divisor fraction, the dividend is shifted up one hex digit and the exponent is one lower (bias 64 instead of 65).
- R5: The six-digit quotient is incremented when the final remainder is at least half a divisor, ties included. A carry out of the fraction shifts it right one hex digit and raises the exponent by one.
- R6: Operands with leading zero hex digits are normalized before dividing: the fraction is shifted up and the exponent lowered by one per digit.
- R7: A zero dividend fraction gives the all-zero word with condCode 0, whatever its sign and exponent.
- R8: A zero divisor fraction sets divCheck at done and leaves quotientOut and condCode unchanged. Any other division clears divCheck.
- R9: A biased exponent above 127 gives exponent and fraction all ones with the sign kept. condCode then has bit 2 set, plus the sign bit (bit 0 if negative, bit 1 if positive). A result exponent of exactly 127 is a normal result.
- R10: A biased exponent of 0 or below gives the all-zero word with condCode 3'b100. Exponent 1 is a normal result.
- R11: condCode encoding is bit 0 = negative result, bit 1 = positive nonzero result, bit 2 = out of range. A zero result gives 3'b000, and bits 0 and 1 are never both set.
- R12: doneOut is a one-cycle pulse per accepted start, at most 100 cycles after it. A start seen while a division is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Start strobe, accepted when idle |
| dividendIn | input | 32 | Dividend word, sampled with startReq |
| divisorIn | input | 32 | Divisor word, sampled with startReq |
| quotientOut | output | 32 | Packed quotient, updated with doneOut |
| doneOut | output | 1 | One-cycle completion pulse |
| condCode | output | 3 | {out of range, positive, negative} |
| divCheck | output | 1 | Divisor fraction was zero (valid at doneOut) |

## Verification
Vectors with an exact ratio and a zero remainder separate the digit loop from rounding. A repeating-digit ratio (2/3) and an exact half-divisor remainder show that rounding rounds ties up. Mixed-sign pairs separate the sign rule from the magnitude path. Ratios above and below one separate the two exponent biases that the pre-scale selects. Unnormalized operands check the leading-digit shift. Exponent sums placed at 0, 1, 127 and 128 locate the underflow and overflow boundaries exactly. A zero divisor issued right after a known result shows the held outputs, and a second start issued mid-run shows that it is ignored.

// File: rtl/hfd_pkg.sv
package hfd_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadOps;    // capture and prepare operands
    logic stepSub;    // one restoring subtraction
    logic stepShift;  // close the current digit
    logic finish;     // round, pack, publish
  } hfdCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } hfdState_t;

endpackage

// File: rtl/hfd_unpack.sv
module hfd_unpack #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 7
) (
  input  logic [1+EXP_W+FRAC_W-1:0]    word,
  output logic                         sign,
  output logic signed [EXP_W+2:0]      expN,
  output logic [FRAC_W-1:0]            fracN,
  output logic                         isZero
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int ES_W   = EXP_W + 3;
  localparam int DIGITS = FRAC_W / 4;
  localparam int LZ_W   = $clog2(DIGITS + 1);

  logic [FRAC_W-1:0] fracRaw;
  logic [LZ_W-1:0]   lzCount;
  logic              seenDigit;

  assign fracRaw = word[FRAC_W-1:0];
  assign isZero  = (fracRaw == '0);

  // Count leading zero hex digits
  always_comb begin
    lzCount   = '0;
    seenDigit = 1'b0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      if (!seenDigit) begin
        if (fracRaw[i*4 +: 4] != 4'h0) seenDigit = 1'b1;
        else lzCount = lzCount + 1'b1;
      end
    end
  end

  always_comb begin
    if (isZero) begin
      sign  = 1'b0;
      expN  = '0;
      fracN = '0;
    end else begin
      sign  = word[WORD_W-1];
      fracN = fracRaw << {lzCount, 2'b00};
      expN  = $signed({{(ES_W-EXP_W){1'b0}}, word[WORD_W-2 -: EXP_W]})
            - $signed({{(ES_W-LZ_W){1'b0}}, lzCount});
    end
  end
endmodule

// File: rtl/hfd_ctrl.sv
module hfd_ctrl
  import hfd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     startReq,
  input  logic     specialCase,
  input  logic     remGeDiv,
  input  logic     lastDigit,
  output hfdCtrl_t ctrl
);
  hfdState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctrl.loadOps = 1'b1;
          stateNxt     = ST_RUN;
        end
      end
      ST_RUN: begin
        if (specialCase) begin
          stateNxt = ST_FIN;
        end else if (remGeDiv) begin
          ctrl.stepSub = 1'b1;
        end else begin
          ctrl.stepShift = 1'b1;
          if (lastDigit) stateNxt = ST_FIN;
        end
      end
      ST_FIN: begin
        ctrl.finish = 1'b1;
        stateNxt    = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/hfd_dpath.sv
module hfd_dpath
  import hfd_pkg::*;
#(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  hfdCtrl_t                     ctrl,
  input  logic [1+EXP_W+FRAC_W-1:0]    dividendIn,
  input  logic [1+EXP_W+FRAC_W-1:0]    divisorIn,
  output logic                         remGeDiv,
  output logic                         lastDigit,
  output logic                         specialCase,
  output logic [1+EXP_W+FRAC_W-1:0]    quotientOut,
  output logic [2:0]                   condCode,
  output logic                         divCheck,
  output logic                         doneOut
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int ES_W   = EXP_W + 3;
  localparam int REM_W  = FRAC_W + 4;
  localparam int DIGITS = FRAC_W / 4;
  localparam int CNT_W  = $clog2(DIGITS);
  localparam int BIAS   = 1 << (EXP_W - 1);
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam logic signed [ES_W-1:0] BIAS_S = ES_W'(BIAS);
  localparam logic signed [ES_W-1:0] EMAX_S = ES_W'(EMAX);
  localparam logic signed [ES_W-1:0] ONE_S  = ES_W'(1);
  localparam logic signed [ES_W-1:0] ZERO_S = '0;

  // Operand normalizers
  logic                     signA, signB, zeroA, zeroB;
  logic signed [ES_W-1:0]   expA, expB;
  logic [FRAC_W-1:0]        fracA, fracB;

  hfd_unpack #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) uUnpackDvd (
    .word(dividendIn), .sign(signA), .expN(expA), .fracN(fracA), .isZero(zeroA)
  );
  hfd_unpack #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) uUnpackDvs (
    .word(divisorIn), .sign(signB), .expN(expB), .fracN(fracB), .isZero(zeroB)
  );

  // Working state
  logic [REM_W-1:0]       remR;
  logic [FRAC_W-1:0]      divR;
  logic [FRAC_W-1:0]      quoR;
  logic signed [ES_W-1:0] expR;
  logic                   signR;
  logic [CNT_W-1:0]       digitR;
  logic                   zeroDvdR, zeroDvsR;

  // Pre-scale decision at load
  logic                   geFirst;
  logic signed [ES_W-1:0] expLoad;
  logic [REM_W-1:0]       remLoad;

  assign geFirst = (fracA >= fracB);
  assign expLoad = expA - expB + BIAS_S + (geFirst ? ONE_S : ZERO_S);
  assign remLoad = geFirst ? {4'h0, fracA} : {fracA, 4'h0};

  assign remGeDiv    = (remR >= {4'h0, divR});
  assign lastDigit   = (digitR == CNT_W'(DIGITS - 1));
  assign specialCase = zeroDvdR | zeroDvsR;

  always_ff @(posedge clk) begin
    if (rst) begin
      remR     <= '0;
      divR     <= '0;
      quoR     <= '0;
      expR     <= '0;
      signR    <= 1'b0;
      digitR   <= '0;
      zeroDvdR <= 1'b0;
      zeroDvsR <= 1'b0;
    end else if (ctrl.loadOps) begin
      remR     <= remLoad;
      divR     <= fracB;
      quoR     <= '0;
      expR     <= expLoad;
      signR    <= signA ^ signB;
      digitR   <= '0;
      zeroDvdR <= zeroA;
      zeroDvsR <= zeroB;
    end else if (ctrl.stepSub) begin
      remR <= remR - {4'h0, divR};
      quoR <= quoR + 1'b1;
    end else if (ctrl.stepShift) begin
      remR <= remR << 4;
      if (!lastDigit) begin
        quoR   <= quoR << 4;
        digitR <= digitR + 1'b1;
      end
    end
  end

  // Rounding and packing
  logic                   roundUp;
  logic [FRAC_W:0]        qRnd;
  logic [FRAC_W-1:0]      fracFin;
  logic signed [ES_W-1:0] expFin;
  logic [WORD_W-1:0]      wordNxt;
  logic [2:0]             ccNxt;

  assign roundUp = (remR >= {1'b0, divR, 3'b000});
  assign qRnd    = {1'b0, quoR} + {{FRAC_W{1'b0}}, roundUp};
  assign fracFin = qRnd[FRAC_W] ? qRnd[FRAC_W:1] >> 3 : qRnd[FRAC_W-1:0];
  assign expFin  = qRnd[FRAC_W] ? expR + ONE_S : expR;

  always_comb begin
    if (zeroDvdR) begin
      wordNxt = '0;
      ccNxt   = 3'b000;
    end else if (expFin <= ZERO_S) begin
      wordNxt = '0;
      ccNxt   = 3'b100;
    end else if (expFin > EMAX_S) begin
      wordNxt = {signR, {(WORD_W-1){1'b1}}};
      ccNxt   = {1'b1, ~signR, signR};
    end else begin
      wordNxt = {signR, expFin[EXP_W-1:0], fracFin};
      ccNxt   = {1'b0, ~signR, signR};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quotientOut <= '0;
      condCode    <= '0;
      divCheck    <= 1'b0;
      doneOut     <= 1'b0;
    end else begin
      doneOut <= ctrl.finish;
      if (ctrl.finish) begin
        divCheck <= zeroDvsR;
        if (!zeroDvsR) begin
          quotientOut <= wordNxt;
          condCode    <= ccNxt;
        end
      end
    end
  end
endmodule

// File: rtl/hex_float_div.sv
module hex_float_div
  import hfd_pkg::*;
#(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       startReq,
  input  logic [1+EXP_W+FRAC_W-1:0]  dividendIn,
  input  logic [1+EXP_W+FRAC_W-1:0]  divisorIn,
  output logic [1+EXP_W+FRAC_W-1:0]  quotientOut,
  output logic                       doneOut,
  output logic [2:0]                 condCode,
  output logic                       divCheck
);
  hfdCtrl_t ctrl;
  logic     remGeDiv, lastDigit, specialCase;

  hfd_ctrl uCtrl (
    .clk(clk), .rst(rst), .startReq(startReq),
    .specialCase(specialCase), .remGeDiv(remGeDiv), .lastDigit(lastDigit),
    .ctrl(ctrl)
  );

  hfd_dpath #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) uDpath (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .remGeDiv(remGeDiv), .lastDigit(lastDigit), .specialCase(specialCase),
    .quotientOut(quotientOut), .condCode(condCode),
    .divCheck(divCheck), .doneOut(doneOut)
  );
endmodule

// File: rtl/hex_float_div_chk.sv
module hex_float_div_chk #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 7
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       startReq,
  input logic [1+EXP_W+FRAC_W-1:0]  quotientOut,
  input logic                       doneOut,
  input logic [2:0]                 condCode,
  input logic                       divCheck
);
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int LAT_MAX = (FRAC_W / 4) * 16 + 4;
  localparam int CW      = $clog2(LAT_MAX + 2) + 1;

  logic          pending;
  logic [CW-1:0] latCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      latCnt  <= '0;
    end else if (!pending || doneOut) begin
      pending <= startReq;
      latCnt  <= '0;
    end else begin
      latCnt <= latCnt + 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut); // R12
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    doneOut |-> pending); // R12
  AST_LATENCY_BOUND: assert property (@(posedge clk) disable iff (rst)
    pending |-> (latCnt <= CW'(LAT_MAX))); // R12
  AST_CC_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    doneOut |-> !(condCode[1] && condCode[0])); // R11
  AST_OVERFLOW_WORD: assert property (@(posedge clk) disable iff (rst)
    (doneOut && !divCheck && condCode[2] && (condCode[1:0] != 2'b00))
      |-> (quotientOut[WORD_W-2:0] == {(WORD_W-1){1'b1}})); // R9
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (doneOut && !divCheck && condCode == 3'b100) |-> (quotientOut == '0)); // R10
  AST_DIVCHECK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (doneOut && divCheck) |-> ($stable(quotientOut) && $stable(condCode))); // R8
  AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !doneOut |-> ($stable(quotientOut) && $stable(condCode))); // R12
endmodule

bind hex_float_div hex_float_div_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) uChk (
  .clk(clk), .rst(rst), .startReq(startReq), .quotientOut(quotientOut),
  .doneOut(doneOut), .condCode(condCode), .divCheck(divCheck)
);

// File: tb/sim_hex_float_div.sv
`timescale 1ns/1ps
module sim_hex_float_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startReq = 1'b0;
  logic [31:0] dividendIn = '0;
  logic [31:0] divisorIn = '0;
  logic [31:0] quotientOut;
  logic        doneOut;
  logic [2:0]  condCode;
  logic        divCheck;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  hex_float_div u0 (
    .clk(clk), .rst(rst), .startReq(startReq),
    .dividendIn(dividendIn), .divisorIn(divisorIn),
    .quotientOut(quotientOut), .doneOut(doneOut),
    .condCode(condCode), .divCheck(divCheck)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] q;
    logic [2:0]  cc;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{32'h41100000, 32'h41100000, 32'h41100000, 3'b010, "R2 "},
    '{32'h42300000, 32'h41200000, 32'h42180000, 3'b010, "R2 "},
    '{32'hC2300000, 32'h41200000, 32'hC2180000, 3'b001, "R3 "},
    '{32'hC2300000, 32'hC1200000, 32'h42180000, 3'b010, "R3 "},
    '{32'h41100000, 32'h41300000, 32'h40555555, 3'b010, "R4 "},
    '{32'h41200000, 32'h41300000, 32'h40AAAAAB, 3'b010, "R5 "},
    '{32'h41300001, 32'h41200000, 32'h41180001, 3'b010, "R5 "},
    '{32'h42010000, 32'h41100000, 32'h41100000, 3'b010, "R6 "},
    '{32'h41200000, 32'h42008000, 32'h41400000, 3'b010, "R6 "},
    '{32'h00000000, 32'h41100000, 32'h00000000, 3'b000, "R7 "},
    '{32'h85000000, 32'h41100000, 32'h00000000, 3'b000, "R7 "},
    '{32'h7F100000, 32'h00100000, 32'h7FFFFFFF, 3'b110, "R9 "},
    '{32'hFF100000, 32'h00100000, 32'hFFFFFFFF, 3'b101, "R9 "},
    '{32'h7F100000, 32'h40100000, 32'h7FFFFFFF, 3'b110, "R9 "},
    '{32'h7F100000, 32'h41100000, 32'h7F100000, 3'b010, "R9 "},
    '{32'h00100000, 32'h7F100000, 32'h00000000, 3'b100, "R10"},
    '{32'h00100000, 32'h41100000, 32'h00000000, 3'b100, "R10"},
    '{32'h01100000, 32'h41100000, 32'h01100000, 3'b010, "R10"}
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Launch one division and wait for done; samples at the falling edge
  task automatic runDiv(input logic [31:0] a, input logic [31:0] b, output logic ok);
    int n;
    @(negedge clk);
    dividendIn = a;
    divisorIn  = b;
    startReq   = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    n = 0;
    while (!doneOut && n < 400) begin
      @(negedge clk);
      n++;
    end
    ok = doneOut;
    if (!ok) check("R12 done timeout", 32'd0, 32'd1);
  endtask

  initial begin
    #1ms;
    fails++;
    tests++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ok;
    logic [31:0] heldQ;
    logic [2:0]  heldCc;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 quotientOut", quotientOut, 32'h0);
    check("R1 condCode", {29'd0, condCode}, 32'h0);
    check("R1 divCheck", {31'd0, divCheck}, 32'h0);
    check("R1 doneOut", {31'd0, doneOut}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      runDiv(VEC[i].a, VEC[i].b, ok);
      if (ok) begin
        check($sformatf("%s vec%0d quotient", VEC[i].tag, i), quotientOut, VEC[i].q);
        check($sformatf("%s vec%0d cc (R11)", VEC[i].tag, i), {29'd0, condCode}, {29'd0, VEC[i].cc});
        check($sformatf("R8 vec%0d divCheck clear", i), {31'd0, divCheck}, 32'h0);
        @(negedge clk);
        check($sformatf("R12 vec%0d done single cycle", i), {31'd0, doneOut}, 32'h0);
      end
    end

    // R8: zero divisor holds the previous result and flags divide-check
    runDiv(32'hC2300000, 32'h41200000, ok);
    heldQ  = 32'hC2180000;
    heldCc = 3'b001;
    runDiv(32'h41100000, 32'h00000000, ok);
    check("R8 divCheck set", {31'd0, divCheck}, 32'h1);
    check("R8 quotient held", quotientOut, heldQ);
    check("R8 cc held", {29'd0, condCode}, {29'd0, heldCc});
    runDiv(32'h42000000, 32'h43000000, ok);
    check("R8 divCheck set, zero divisor with exponent", {31'd0, divCheck}, 32'h1);
    check("R8 quotient still held", quotientOut, heldQ);
    runDiv(32'h41100000, 32'h41100000, ok);
    check("R8 divCheck cleared", {31'd0, divCheck}, 32'h0);
    check("R8 result after clear", quotientOut, 32'h41100000);

    // R12: a start during a running division is ignored
    @(negedge clk);
    dividendIn = 32'h41200000;
    divisorIn  = 32'h41300000;
    startReq   = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (4) @(negedge clk);
    dividendIn = 32'hC2300000;
    divisorIn  = 32'h41200000;
    startReq   = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    begin
      int n = 0;
      while (!doneOut && n < 400) begin
        @(negedge clk);
        n++;
      end
    end
    check("R12 busy start ignored, quotient", quotientOut, 32'h40AAAAAB);
    check("R12 busy start ignored, cc", {29'd0, condCode}, 32'h2);
    repeat (110) begin
      @(negedge clk);
      if (doneOut) check("R12 no extra done", 32'd1, 32'd0);
    end
    check("R12 quiet after ignored start", quotientOut, 32'h40AAAAAB);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule